// File: doc/BRIEF.md
# Pipelined Multiply-Add ALU Slice

This block is one arithmetic slice for a datapath. Each clock it takes a 30-bit operand A, an 18-bit operand B and a 48-bit operand C. It forms the signed product of the low 25 bits of A with B and feeds that product, C and its own registered result into a 48-bit adder/subtractor. Three multiplexers (X, Y and Z) choose the adder's terms. A 7-bit operation code sets the multiplexers, and a 4-bit ALU code picks between add, subtract and negated subtract. A 5-bit input-mode code can force either multiplier operand to zero.

Every operand and control enters through one register stage. The product has its own register, and so does the result. As a result, the timing from any input to P is fixed. The typical use runs a computation in two steps:

- A multiply step: the product, optionally combined with C, is captured in P.
- A drain step: X selects P, Y and Z give zero, and the ALU adds. The finished value then stays stable while another unit stores it.

In normal use C carries the constant 48'h0000_0009_5514, but it remains an ordinary input.

Top module: `muladd_slice`

## Requirements
- R1: A synchronous active-high `rst` clears every pipeline register. `p_out` reads zero after the first clock edge at which `rst` is high.
- R2: `a_in`, `b_in` and `in_mode` reach `p_out` three clock edges after they are applied. `c_in`, `op_mode` and `alu_mode` reach it two edges after they are applied.
- R3: The product is the signed value of `a_in[24:0]` times the signed value of `b_in`, sign-extended to 48 bits. `a_in[29:25]` have no effect on `p_out`.
- R4: `in_mode[1]`=1 forces the A operand of the multiplier to zero. `in_mode[4]`=1 forces the B operand to zero. `in_mode[0]`, `in_mode[2]` and `in_mode[3]` have no effect.
- R5: `op_mode[1:0]` selects X, `op_mode[3:2]` selects Y and `op_mode[6:4]` selects Z, all taken from the registered controls.
- R6: The product enters the sum only when X=01 and Y=01. If only one of the two selects is 01, that multiplexer gives zero.
- R7: X=10 gives the registered result P. X=00 and X=11 give zero.
- R8: Y=00 gives zero, Y=10 gives all ones and Y=11 gives C.
- R9: Z=010 gives P, Z=011 gives C, and every other Z code gives zero.
- R10: ALU code 0000 yields Z+X+Y modulo 2^48. Any code other than 0000, 0001 and 0011 behaves as 0000.
- R11: ALU code 0011 yields Z-(X+Y) modulo 2^48.
- R12: ALU code 0001 yields (X+Y)-Z-1 modulo 2^48.
- R13: While the operation code is 0000010 and the ALU code is 0000, `p_out` keeps its value from edge to edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 30 | Multiplier operand A (low 25 bits used, signed) |
| b_in | input | 18 | Multiplier operand B, signed |
| c_in | input | 48 | Adder operand C |
| alu_mode | input | 4 | Arithmetic function code |
| op_mode | input | 7 | X/Y/Z multiplexer selects |
| in_mode | input | 5 | Multiplier operand gating |
| p_out | output | 48 | Registered result |

## Verification
Some relations are checked by the assertions on every cycle:
- a drained result holds steady;
- an all-zero selection empties P;
- the all-ones Y term and the negated subtract of zeros give all ones;
- C minus nothing returns the registered C;
- a gated A operand empties the product register.

Other behaviour can only be shown by the bench scenarios: the exact three-edge and two-edge alignment of operands and controls, the signed product with ignored upper A bits, the pairing rule for the product term, accumulation through Z, and the handling of unlisted ALU codes. The bench covers these by comparing every result cycle against an independent model.

// File: rtl/muladd_pkg.sv
package muladd_pkg;

  parameter int A_W   = 30;
  parameter int B_W   = 18;
  parameter int C_W   = 48;
  parameter int P_W   = 48;
  parameter int MA_W  = 25;
  parameter int ALU_W = 4;
  parameter int OP_W  = 7;
  parameter int IN_W  = 5;

  localparam int M_W = MA_W + B_W;

  localparam logic [1:0] XS_MUL = 2'b01;
  localparam logic [1:0] XS_P   = 2'b10;
  localparam logic [1:0] YS_MUL = 2'b01;
  localparam logic [1:0] YS_ONE = 2'b10;
  localparam logic [1:0] YS_C   = 2'b11;
  localparam logic [2:0] ZS_P   = 3'b010;
  localparam logic [2:0] ZS_C   = 3'b011;

  localparam logic [ALU_W-1:0] ALU_ADD  = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_NSUB = 4'b0001;
  localparam logic [ALU_W-1:0] ALU_SUB  = 4'b0011;

  localparam int IN_ZA_BIT = 1;
  localparam int IN_ZB_BIT = 4;

  localparam logic [P_W-1:0] ONE_P = {{(P_W-1){1'b0}}, 1'b1};

  // Signed low-A times B, with optional operand gating, sign-extended.
  function automatic logic [P_W-1:0] mul_ext(input logic [A_W-1:0] a,
                                             input logic [B_W-1:0] b,
                                             input logic [IN_W-1:0] im);
    logic signed [MA_W-1:0] ao;
    logic signed [B_W-1:0]  bo;
    logic signed [M_W-1:0]  pr;
    ao = im[IN_ZA_BIT] ? '0 : a[MA_W-1:0];
    bo = im[IN_ZB_BIT] ? '0 : b;
    pr = ao * bo;
    return {{(P_W-M_W){pr[M_W-1]}}, pr};
  endfunction

  function automatic logic [P_W-1:0] x_pick(input logic [OP_W-1:0] op,
                                            input logic [P_W-1:0] m,
                                            input logic [P_W-1:0] p);
    case (op[1:0])
      XS_MUL:  return (op[3:2] == YS_MUL) ? m : '0;
      XS_P:    return p;
      default: return '0;
    endcase
  endfunction

  function automatic logic [P_W-1:0] y_pick(input logic [OP_W-1:0] op,
                                            input logic [C_W-1:0] c);
    case (op[3:2])
      YS_ONE:  return '1;
      YS_C:    return c;
      default: return '0;
    endcase
  endfunction

  function automatic logic [P_W-1:0] z_pick(input logic [OP_W-1:0] op,
                                            input logic [P_W-1:0] p,
                                            input logic [C_W-1:0] c);
    case (op[6:4])
      ZS_P:    return p;
      ZS_C:    return c;
      default: return '0;
    endcase
  endfunction

  function automatic logic [P_W-1:0] alu_eval(input logic [ALU_W-1:0] mode,
                                              input logic [P_W-1:0] x,
                                              input logic [P_W-1:0] y,
                                              input logic [P_W-1:0] z);
    logic [P_W-1:0] s;
    s = x + y;
    case (mode)
      ALU_SUB:  return z - s;
      ALU_NSUB: return s - z - ONE_P;
      default:  return z + s;
    endcase
  endfunction

endpackage

// File: rtl/muladd_pipe.sv
module muladd_pipe #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/muladd_mult.sv
module muladd_mult
  import muladd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [A_W-1:0]  a_q,
  input  logic [B_W-1:0]  b_q,
  input  logic [IN_W-1:0] in_q,
  output logic [P_W-1:0]  m_q
);
  logic [P_W-1:0] prod_w;

  assign prod_w = mul_ext(a_q, b_q, in_q);

  always_ff @(posedge clk) begin
    if (rst) m_q <= '0;
    else     m_q <= prod_w;
  end
endmodule

// File: rtl/muladd_alu.sv
module muladd_alu
  import muladd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [P_W-1:0]   m_q,
  input  logic [C_W-1:0]   c_q,
  input  logic [OP_W-1:0]  op_q,
  input  logic [ALU_W-1:0] alu_q,
  output logic [P_W-1:0]   p_q
);
  logic [P_W-1:0] x_v;
  logic [P_W-1:0] y_v;
  logic [P_W-1:0] z_v;
  logic [P_W-1:0] sum_next;

  assign x_v      = x_pick(op_q, m_q, p_q);
  assign y_v      = y_pick(op_q, c_q);
  assign z_v      = z_pick(op_q, p_q, c_q);
  assign sum_next = alu_eval(alu_q, x_v, y_v, z_v);

  always_ff @(posedge clk) begin
    if (rst) p_q <= '0;
    else     p_q <= sum_next;
  end
endmodule

// File: rtl/muladd_slice.sv
module muladd_slice
  import muladd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic [C_W-1:0]   c_in,
  input  logic [ALU_W-1:0] alu_mode,
  input  logic [OP_W-1:0]  op_mode,
  input  logic [IN_W-1:0]  in_mode,
  output logic [P_W-1:0]   p_out
);
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic [C_W-1:0]   c_q;
  logic [ALU_W-1:0] alu_q;
  logic [OP_W-1:0]  op_q;
  logic [IN_W-1:0]  in_q;
  logic [P_W-1:0]   m_q;

  muladd_pipe #(.W(A_W))   u_a_reg   (.clk(clk), .rst(rst), .d(a_in),     .q(a_q));
  muladd_pipe #(.W(B_W))   u_b_reg   (.clk(clk), .rst(rst), .d(b_in),     .q(b_q));
  muladd_pipe #(.W(C_W))   u_c_reg   (.clk(clk), .rst(rst), .d(c_in),     .q(c_q));
  muladd_pipe #(.W(ALU_W)) u_alu_reg (.clk(clk), .rst(rst), .d(alu_mode), .q(alu_q));
  muladd_pipe #(.W(OP_W))  u_op_reg  (.clk(clk), .rst(rst), .d(op_mode),  .q(op_q));
  muladd_pipe #(.W(IN_W))  u_in_reg  (.clk(clk), .rst(rst), .d(in_mode),  .q(in_q));

  muladd_mult u_mult (
    .clk (clk),
    .rst (rst),
    .a_q (a_q),
    .b_q (b_q),
    .in_q(in_q),
    .m_q (m_q)
  );

  muladd_alu u_alu (
    .clk  (clk),
    .rst  (rst),
    .m_q  (m_q),
    .c_q  (c_q),
    .op_q (op_q),
    .alu_q(alu_q),
    .p_q  (p_out)
  );
endmodule

// File: rtl/muladd_slice_chk.sv
module muladd_slice_chk
  import muladd_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [OP_W-1:0]  op_q,
  input logic [ALU_W-1:0] alu_q,
  input logic [IN_W-1:0]  in_q,
  input logic [C_W-1:0]   c_q,
  input logic [P_W-1:0]   m_q,
  input logic [P_W-1:0]   p_out
);
  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op_q == 7'b000_00_10 && alu_q == ALU_ADD) |=> (p_out == $past(p_out))); // R13

  AST_ZERO_SELECT: assert property (@(posedge clk) disable iff (rst)
    (op_q == '0 && alu_q == ALU_ADD) |=> (p_out == '0)); // R9

  AST_A_GATED: assert property (@(posedge clk) disable iff (rst)
    in_q[IN_ZA_BIT] |=> (m_q == '0)); // R4

  AST_C_MINUS_NONE: assert property (@(posedge clk) disable iff (rst)
    (op_q == 7'b011_00_00 && alu_q == ALU_SUB) |=> (p_out == $past(c_q))); // R11

  AST_NSUB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_q == '0 && alu_q == ALU_NSUB) |=> (p_out == '1)); // R12

  AST_Y_ONES: assert property (@(posedge clk) disable iff (rst)
    (op_q == 7'b000_10_00 && alu_q == ALU_ADD) |=> (p_out == '1)); // R8
endmodule

bind muladd_slice muladd_slice_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .op_q (op_q),
  .alu_q(alu_q),
  .in_q (in_q),
  .c_q  (c_q),
  .m_q  (m_q),
  .p_out(p_out)
);

// File: tb/test_muladd_slice.sv
module test_muladd_slice;

  localparam logic [47:0] KC = 48'h0000_0009_5514;

  typedef struct {
    logic        r;
    logic [29:0] a;
    logic [17:0] b;
    logic [47:0] c;
    logic [3:0]  al;
    logic [6:0]  op;
    logic [4:0]  im;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst;
  logic [29:0] a_in;
  logic [17:0] b_in;
  logic [47:0] c_in;
  logic [3:0]  alu_mode;
  logic [6:0]  op_mode;
  logic [4:0]  in_mode;
  logic [47:0] p_out;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  item_t q[$];

  muladd_slice i_muladd_slice (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .alu_mode(alu_mode), .op_mode(op_mode), .in_mode(in_mode), .p_out(p_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Independent reference arithmetic
  function automatic logic [47:0] ref_prod(logic [29:0] a, logic [17:0] b, logic [4:0] im);
    longint av, bv, pr;
    av = 0;
    bv = 0;
    if (!im[1]) begin
      av = longint'(a[24:0]);
      if (a[24]) av = av - 64'sd33554432;
    end
    if (!im[4]) begin
      bv = longint'(b);
      if (b[17]) bv = bv - 64'sd262144;
    end
    pr = av * bv;
    return pr[47:0];
  endfunction

  function automatic logic [47:0] ref_alu(logic [3:0] al, logic [6:0] op, logic [47:0] mq,
                                          logic [47:0] pq, logic [47:0] c);
    logic [47:0] xv, yv, zv, t;
    if (op[1:0] == 2'b10) xv = pq;
    else if (op[1:0] == 2'b01 && op[3:2] == 2'b01) xv = mq;
    else xv = '0;
    yv = (op[3:2] == 2'b11) ? c : ((op[3:2] == 2'b10) ? {48{1'b1}} : 48'd0);
    zv = (op[6:4] == 3'b011) ? c : ((op[6:4] == 3'b010) ? pq : 48'd0);
    t  = xv + yv;
    if (al == 4'b0011)      return zv - t;
    else if (al == 4'b0001) return t + ~zv;
    else                    return zv + t;
  endfunction

  task automatic drive(input logic r, input logic [29:0] a, input logic [17:0] b,
                       input logic [47:0] c, input logic [3:0] al, input logic [6:0] op,
                       input logic [4:0] im, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; a_in = a; b_in = b; c_in = c; alu_mode = al; op_mode = op; in_mode = im;
    it.r = r; it.a = a; it.b = b; it.c = c; it.al = al; it.op = op; it.im = im; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic hold(input int n, input logic [29:0] a, input logic [17:0] b,
                      input logic [47:0] c, input logic [3:0] al, input logic [6:0] op,
                      input logic [4:0] im, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, a, b, c, al, op, im, tag);
  endtask

  // Monitor: pops the item captured at each edge and scores the result
  initial begin
    item_t s1, it;
    logic [47:0] mq, pq;
    string tg;
    s1 = '{r:1'b0, a:'0, b:'0, c:'0, al:'0, op:'0, im:'0, tag:"R1 post-reset"};
    mq = '0;
    pq = '0;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.r) begin
          s1 = '{r:1'b0, a:'0, b:'0, c:'0, al:'0, op:'0, im:'0, tag:"R1 post-reset"};
          mq = '0;
          pq = '0;
          tg = "R1 reset";
        end else begin
          tg = s1.tag;
          pq = ref_alu(s1.al, s1.op, mq, pq, s1.c);
          mq = ref_prod(s1.a, s1.b, s1.im);
          s1 = it;
        end
        #2;
        checks++;
        if (p_out !== pq) begin
          errors++;
          $display("FAIL %s: p_out=%h expected %h", tg, p_out, pq);
        end
      end
    end
  end

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0; c_in = '0;
    alu_mode = '0; op_mode = '0; in_mode = '0;
    for (int i = 0; i < 3; i++) drive(1'b1, '0, '0, '0, '0, '0, '0, "R1");
    // R2 R3 R10: plain product, then a latency step as operands change
    hold(3, 30'd7, 18'd13, KC, 4'b0000, 7'b000_01_01, 5'b0, "R2 R3 R10 product");
    hold(3, 30'd1000, 18'd999, KC, 4'b0000, 7'b000_01_01, 5'b0, "R2 R3 product step");
    // R3: negative operands and ignored upper A bits
    hold(3, 30'h01FF_FFFF, 18'd5, KC, 4'b0000, 7'b000_01_01, 5'b0, "R3 negative A");
    hold(3, 30'h3E00_0003, 18'h3FFF9, KC, 4'b0000, 7'b000_01_01, 5'b0, "R3 upper A ignored");
    // R9 R10: product plus C; R11 C minus product; R12 product minus C minus one
    hold(3, 30'd321, 18'd77, KC, 4'b0000, 7'b011_01_01, 5'b0, "R9 R10 product+C");
    hold(3, 30'd321, 18'd77, KC, 4'b0011, 7'b011_01_01, 5'b0, "R11 C-product");
    hold(3, 30'd321, 18'd77, KC, 4'b0001, 7'b011_01_01, 5'b0, "R12 product-C-1");
    // R7 R13: drain holds the result
    hold(5, 30'd55, 18'd66, 48'h1234, 4'b0000, 7'b000_00_10, 5'b0, "R7 R13 drain");
    // R9: accumulate through Z=P
    hold(4, 30'd11, 18'd3, KC, 4'b0000, 7'b010_01_01, 5'b0, "R9 accumulate");
    hold(3, 30'd11, 18'd3, KC, 4'b0000, 7'b000_00_11, 5'b0, "R7 X=11 zero");
    // R6: only one of the pair at 01
    hold(3, 30'd40, 18'd40, KC, 4'b0000, 7'b000_00_01, 5'b0, "R6 X only");
    hold(3, 30'd40, 18'd40, KC, 4'b0000, 7'b000_01_00, 5'b0, "R6 Y only");
    // R5 R8: Y codes
    hold(3, 30'd2, 18'd2, KC, 4'b0000, 7'b000_10_00, 5'b0, "R5 R8 Y ones");
    hold(3, 30'd2, 18'd2, 48'hABCD_0000_1111, 4'b0000, 7'b000_11_00, 5'b0, "R8 Y=C");
    // R9: other Z codes give zero
    hold(3, 30'd9, 18'd9, KC, 4'b0000, 7'b101_01_01, 5'b0, "R9 Z other");
    // R4: operand gating and ignored mode bits
    hold(4, 30'd123, 18'd45, KC, 4'b0000, 7'b000_01_01, 5'b00010, "R4 A gated");
    hold(4, 30'd123, 18'd45, KC, 4'b0000, 7'b000_01_01, 5'b10000, "R4 B gated");
    hold(4, 30'd123, 18'd45, KC, 4'b0000, 7'b000_01_01, 5'b01101, "R4 unused bits");
    // R10: unlisted ALU code acts as add
    hold(3, 30'd17, 18'd19, KC, 4'b0101, 7'b011_01_01, 5'b0, "R10 unlisted code");
    hold(2, 30'd0, 18'd0, '0, 4'b0001, 7'b000_00_00, 5'b0, "R12 zero terms");
    // R1: mid-run reset
    drive(1'b1, 30'd5, 18'd5, KC, 4'b0000, 7'b000_01_01, 5'b0, "R1");
    hold(3, 30'd6, 18'd6, KC, 4'b0000, 7'b000_01_01, 5'b0, "R1 R2 after reset");
    // R2 R5: mixed stream, every cycle different
    for (int i = 0; i < 80; i++) begin
      logic [3:0] al;
      case ($urandom % 4)
        0: al = 4'b0000;
        1: al = 4'b0001;
        2: al = 4'b0011;
        default: al = 4'b0110;
      endcase
      drive(1'b0, 30'($urandom), 18'($urandom), {16'($urandom), 32'($urandom)}, al,
            7'($urandom), 5'($urandom), "R2 R5 mixed");
    end
    hold(4, '0, '0, '0, 4'b0000, 7'b000_00_00, 5'b0, "R9 flush");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule